// File: doc/BRIEF.md
# Early-Addressed Two-Read Register File

A register file of 32 words by 32 bits with one write port and two read ports, arranged so that the storage maps onto synchronous block RAM. No read is combinational: each read port takes its index one stage ahead of use, straight from a decoder's combinational outputs. It samples that index, and loads the RAM word, on the edge where the decode-stage enable is high. The read value is then available from the next cycle onward.

The RAM itself gives the old word when a location is written and read on the same edge. To hide this, each read port registers a collision flag on the same enable: the flag is set when a write lands on that port's index at that edge. A single captured copy of the write data is shared by both ports. Each output then shows the captured value when its flag is set, and the RAM word otherwise. Writes take effect on every edge where the write enable is high, whatever the decode enable does. The net effect is that each output equals the register's contents at the sampling edge, including a write made on that same edge.

Top module: `early_read_regfile`

## Requirements
- R1: An edge with `rst_n` low drives both `opnd_a` and `opnd_b` to zero from the next cycle and clears both collision flags.
- R2: On every edge where `wr_en` is high, `wr_data` is stored at word `wr_idx`, whether or not `dec_en` is high.
- R3: On an edge where `dec_en` is high, `opnd_a` shows the word at `pre_idx_a` and `opnd_b` shows the word at `pre_idx_b` from the next cycle. The two ports are independent and may name any words.
- R4: While `dec_en` is low at an edge, neither output changes on that edge, even if a write hits the word the output came from.
- R5: If `dec_en` and `wr_en` are both high and `wr_idx` equals `pre_idx_a` at an edge, `opnd_a` shows that edge's `wr_data` from the next cycle.
- R6: The R5 rule applies to port B through `pre_idx_b`. When both indices equal `wr_idx`, both outputs show the written data.
- R7: A write on the same edge as a read, to an index neither port names, leaves both outputs equal to the stored words at their indices.
- R8: Writes on consecutive edges to one index leave the last value stored. A read sampled on the edge of the later write returns the later value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all registers on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the read-side registers |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Word index written |
| wr_data | input | 32 | Data written |
| dec_en | input | 1 | Decode-stage enable; samples both read indices |
| pre_idx_a | input | 5 | Early read index of port A |
| pre_idx_b | input | 5 | Early read index of port B |
| opnd_a | output | 32 | Read value of port A |
| opnd_b | output | 32 | Read value of port B |

## Verification
The assertions assume that `dec_en`, `wr_en` and the indices are known (not X) at each rising edge once reset is released, and that no word is read before something has been written to it. The RAM array has no reset, so an earlier read would return an undefined word. The bench drives every input at the falling edge, and it writes all 32 words before its first read. The collision checks compare each output with the write data held from the previous edge. They therefore rely on the write data being stable across the sampling edge, which the falling-edge drive guarantees.

// File: rtl/erf_pkg.sv
// Shared constants for the early-addressed register file.
// Assumes: nothing; holds sizes only.
package erf_pkg;
    parameter int ERF_DEF_WORDS = 32;
    parameter int ERF_DEF_WIDTH = 32;
    parameter int ERF_READ_PORTS = 2;
endpackage

// File: rtl/erf_mem.sv
// Storage array with one write port and NRD registered read ports.
// Does: writes on every enabled write edge; each read register loads
// the stored word when rd_en is high. A same-edge write to the read
// word is NOT seen (the old word is returned).
// Assumes: caller resolves write-during-read; array has no reset.
module erf_mem #(
    parameter int WORDS = 32,
    parameter int WIDTH = 32,
    parameter int NRD   = 2,
    localparam int AW   = $clog2(WORDS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [AW-1:0]             wr_idx,
    input  logic [WIDTH-1:0]          wr_data,
    input  logic                      rd_en,
    input  logic [NRD-1:0][AW-1:0]    rd_idx,
    output logic [NRD-1:0][WIDTH-1:0] rd_q
);
    logic [WIDTH-1:0] store [WORDS];

    // Write port: update the array on every write edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        // Read port p: registered read of the old word, sampled on rd_en.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_q[p] <= '0;
            end else if (rd_en) begin
                rd_q[p] <= store[rd_idx[p]];
            end
        end

        // R4
        rdq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en |=> $stable(rd_q[p]));
    end
endmodule

// File: rtl/erf_hazard.sv
// Collision detector for one read port.
// Does: on rd_en, registers whether this edge's write targets the
// port's sampled index.
// Assumes: rd_idx is the same index handed to the storage read.
module erf_hazard #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_idx,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    output logic          hit_q
);
    // Register the write-hits-read condition on the decode enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q <= 1'b0;
        end else if (rd_en) begin
            hit_q <= wr_en && (wr_idx == rd_idx);
        end
    end

    // R1
    hit_reset_chk: assert property (@(posedge clk)
        !rst_n |=> !hit_q);
endmodule

// File: rtl/erf_capture.sv
// Shared capture register for the write data seen at the sampling edge.
// Does: loads wr_data whenever rd_en is high.
// Assumes: consumers qualify it with their own collision flag.
module erf_capture #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] cap_q
);
    // Hold one copy of the write value per sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (rd_en) begin
            cap_q <= wr_data;
        end
    end
endmodule

// File: rtl/early_read_regfile.sv
// Two-read, one-write register file with registered reads.
// Does: samples early read indices on dec_en, reads block-style
// storage, and substitutes a captured write value on a same-edge
// collision so each output equals the word's contents at that edge.
// Assumes: indices arrive one stage early; words are written before read.
module early_read_regfile
    import erf_pkg::*;
#(
    parameter int WORDS = ERF_DEF_WORDS,
    parameter int WIDTH = ERF_DEF_WIDTH,
    localparam int AW   = $clog2(WORDS),
    localparam int NRD  = ERF_READ_PORTS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_idx,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             dec_en,
    input  logic [AW-1:0]    pre_idx_a,
    input  logic [AW-1:0]    pre_idx_b,
    output logic [WIDTH-1:0] opnd_a,
    output logic [WIDTH-1:0] opnd_b
);
    logic [NRD-1:0][AW-1:0]    rd_idx;
    logic [NRD-1:0][WIDTH-1:0] ram_q;
    logic [NRD-1:0][WIDTH-1:0] opnd;
    logic [NRD-1:0]            hit_q;
    logic [WIDTH-1:0]          cap_q;

    // Pack the two early indices into the per-port array.
    always_comb begin
        rd_idx[0] = pre_idx_a;
        rd_idx[1] = pre_idx_b;
    end

    erf_mem #(.WORDS(WORDS), .WIDTH(WIDTH), .NRD(NRD)) u_mem (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_en(dec_en), .rd_idx(rd_idx), .rd_q(ram_q)
    );

    erf_capture #(.WIDTH(WIDTH)) u_cap (
        .clk(clk), .rst_n(rst_n), .rd_en(dec_en),
        .wr_data(wr_data), .cap_q(cap_q)
    );

    for (genvar p = 0; p < NRD; p++) begin : g_port
        erf_hazard #(.AW(AW)) u_haz (
            .clk(clk), .rst_n(rst_n), .rd_en(dec_en),
            .rd_idx(rd_idx[p]), .wr_en(wr_en), .wr_idx(wr_idx),
            .hit_q(hit_q[p])
        );
        // Select the captured write over the stale storage word.
        assign opnd[p] = hit_q[p] ? cap_q : ram_q[p];
    end

    assign opnd_a = opnd[0];
    assign opnd_b = opnd[1];

    // R1
    out_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (opnd_a == '0) && (opnd_b == '0));
    // R4
    hold_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> $stable(opnd_a));
    // R4
    hold_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_en |=> $stable(opnd_b));
    // R5
    collide_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && wr_en && (wr_idx == pre_idx_a)) |=> (opnd_a == $past(wr_data)));
    // R6
    collide_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_en && wr_en && (wr_idx == pre_idx_b)) |=> (opnd_b == $past(wr_data)));
endmodule

// File: tb/test_early_read_regfile.sv
module test_early_read_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 20000;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [4:0]  wr_idx;
    logic [31:0] wr_data;
    logic        dec_en;
    logic [4:0]  pre_idx_a;
    logic [4:0]  pre_idx_b;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;

    int total = 0;
    int bad   = 0;
    logic [31:0] model [32];
    logic [31:0] exp_a;
    logic [31:0] exp_b;

    early_read_regfile i_early_read_regfile (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .dec_en(dec_en), .pre_idx_a(pre_idx_a),
        .pre_idx_b(pre_idx_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    // One cycle: drive at falling edge, model the rising edge, return at next falling edge.
    task automatic step(input logic we, input logic [4:0] wi, input logic [31:0] wd,
                        input logic de, input logic [4:0] ra, input logic [4:0] rb);
        wr_en = we; wr_idx = wi; wr_data = wd;
        dec_en = de; pre_idx_a = ra; pre_idx_b = rb;
        if (we) model[wi] = wd;          // contents at the edge include its write
        if (de) begin
            exp_a = model[ra];
            exp_b = model[rb];
        end
        @(negedge clk);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        step(1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 5'd0);
        step(1'b0, 5'd0, 32'h0, 1'b0, 5'd0, 5'd0);
        exp_a = '0; exp_b = '0;
        chk("R1 opnd_a", opnd_a, 32'h0);
        chk("R1 opnd_b", opnd_b, 32'h0);
        rst_n = 1'b1;
    endtask

    task automatic t_fill_read;
        for (int i = 0; i < 32; i++)
            step(1'b1, 5'(i), 32'hA5A5_0000 ^ (32'(i) * 32'h0101_0103), 1'b0, 5'd0, 5'd0);
        chk("R2 idle write keeps opnd_a", opnd_a, 32'h0);
        for (int i = 0; i < 32; i += 5) begin
            step(1'b0, 5'd0, 32'h0, 1'b1, 5'(i), 5'(31 - i));
            chk("R3 opnd_a", opnd_a, exp_a);
            chk("R3 opnd_b", opnd_b, exp_b);
        end
        step(1'b0, 5'd0, 32'h0, 1'b1, 5'd9, 5'd9);
        chk("R3 same index a", opnd_a, exp_a);
        chk("R3 same index b", opnd_b, exp_b);
    endtask

    task automatic t_hold;
        logic [31:0] ha;
        logic [31:0] hb;
        step(1'b0, 5'd0, 32'h0, 1'b1, 5'd3, 5'd4);
        ha = exp_a; hb = exp_b;
        step(1'b1, 5'd3, 32'hDEAD_0003, 1'b0, 5'd7, 5'd8);
        step(1'b1, 5'd4, 32'hDEAD_0004, 1'b0, 5'd7, 5'd8);
        chk("R4 hold a", opnd_a, ha);
        chk("R4 hold b", opnd_b, hb);
        step(1'b0, 5'd0, 32'h0, 1'b1, 5'd3, 5'd4);
        chk("R2 later read a", opnd_a, 32'hDEAD_0003);
        chk("R2 later read b", opnd_b, 32'hDEAD_0004);
    endtask

    task automatic t_collide_a;
        step(1'b1, 5'd12, 32'h1234_5678, 1'b1, 5'd12, 5'd13);
        chk("R5 collide a", opnd_a, 32'h1234_5678);
        chk("R5 other b", opnd_b, exp_b);
    endtask

    task automatic t_collide_b;
        step(1'b1, 5'd20, 32'h8765_4321, 1'b1, 5'd21, 5'd20);
        chk("R6 collide b", opnd_b, 32'h8765_4321);
        chk("R6 other a", opnd_a, exp_a);
        step(1'b1, 5'd0, 32'hCAFE_F00D, 1'b1, 5'd0, 5'd0);
        chk("R6 both a", opnd_a, 32'hCAFE_F00D);
        chk("R6 both b", opnd_b, 32'hCAFE_F00D);
    endtask

    task automatic t_elsewhere;
        step(1'b1, 5'd30, 32'h0BAD_BEEF, 1'b1, 5'd1, 5'd2);
        chk("R7 a", opnd_a, exp_a);
        chk("R7 b", opnd_b, exp_b);
        step(1'b0, 5'd0, 32'h0, 1'b1, 5'd30, 5'd1);
        chk("R7 write landed", opnd_a, 32'h0BAD_BEEF);
    endtask

    task automatic t_back_to_back;
        step(1'b1, 5'd17, 32'h1111_1111, 1'b1, 5'd17, 5'd16);
        chk("R8 first a", opnd_a, 32'h1111_1111);
        step(1'b1, 5'd17, 32'h2222_2222, 1'b1, 5'd16, 5'd17);
        chk("R8 second b", opnd_b, 32'h2222_2222);
        step(1'b1, 5'd17, 32'h3333_3333, 1'b0, 5'd0, 5'd0);
        step(1'b0, 5'd0, 32'h0, 1'b1, 5'd17, 5'd17);
        chk("R8 last a", opnd_a, 32'h3333_3333);
        chk("R8 last b", opnd_b, 32'h3333_3333);
        // read right after a collision edge, no new write
        step(1'b1, 5'd5, 32'h5555_AAAA, 1'b1, 5'd5, 5'd6);
        step(1'b0, 5'd0, 32'h0, 1'b1, 5'd6, 5'd5);
        chk("R8 following read b", opnd_b, 32'h5555_AAAA);
    endtask

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0;
        dec_en = 1'b0; pre_idx_a = '0; pre_idx_b = '0;
        exp_a = '0; exp_b = '0;
        for (int i = 0; i < 32; i++) model[i] = '0;
        @(negedge clk);
        t_reset();
        t_fill_read();
        t_hold();
        t_collide_a();
        t_collide_b();
        t_elsewhere();
        t_back_to_back();
        t_reset();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WD_LIMIT) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog got=%0d exp=done", WD_LIMIT);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule